// File: doc/BRIEF.md
# Single-Wire Humidity Sensor Reader

This block is the host side of a one-wire link to a combined temperature and humidity sensor. The link is open-drain with an external pull-up. When the block gets a start request it pulls the line low for a long wake-up pulse and then lets it go. After that it checks the timing of the sensor's answer. The answer is a short low/high handshake followed by 40 serial bits. The block reads each bit by measuring how long the sensor holds the line low, counted in clock cycles.

Every timing limit is a cycle count worked out from the clock-frequency parameter as `CLK_FREQ * microseconds / 1_000_000`, truncated. The limits used are:

- 20 µs and 41 µs for the handshake window,
- 60 µs to tell a 1 from a 0,
- 100 µs for the stuck-line timeout,
- `START_US` (18 ms by default) for the wake-up pulse.

The line passes through a two-flop synchronizer before any edge is detected. The block never drives the line high. It either pulls the line low or releases it. A failed handshake, a timeout or a bad checksum ends the transaction in an explicit error state. A good frame updates the humidity and temperature outputs and raises a one-cycle ready pulse.

Top module: `rh_sensor_reader`

## Requirements
- R1: A start_i seen while the block is idle or in error drives line_oe_o high (pull low) for exactly floor(CLK_FREQ*START_US/1e6) cycles, then releases it.
- R2: The host never drives the line high: line_oe_o=1 means pull low, 0 means high impedance, and line_oe_o is only high while busy_o is high.
- R3: After release, the first falling edge of the synchronized line must arrive with the phase counter strictly between the 20 µs and 41 µs counts. An earlier edge, or no edge by the 41 µs count, puts the block in the error state.
- R4: 40 bits are taken MSB first. A bit is 1 when its low phase lasts more than the 60 µs count, else 0. In arrival order the bytes are humidity integer, humidity fraction, temperature integer, temperature fraction, checksum. humidity_o takes the first byte and temperature_o the third.
- R5: The checksum byte must equal the low 8 bits of the sum of the first four bytes. On a mismatch error_o rises, no data_ready_o pulse is issued, and humidity_o and temperature_o keep their previous values.
- R6: Any low or high phase of the handshake or of a data bit that lasts beyond the 100 µs count puts the block in the error state.
- R7: busy_o is high from the cycle after an accepted start until the transaction ends. data_ready_o is a single-cycle pulse with busy_o low, issued only for a valid frame, and the new values are present on the outputs in that same cycle.
- R8: error_o stays high until the next accepted start and is low in the cycle after that start.
- R9: start_i while busy_o is high is ignored: no second wake-up pulse and no disturbance of the frame in progress.
- R10: After reset, busy_o, error_o, data_ready_o and line_oe_o are low and both data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one measurement |
| line_i | input | 1 | Sampled level of the sensor line |
| line_oe_o | output | 1 | 1 pulls the line low, 0 releases it |
| busy_o | output | 1 | Transaction in progress |
| data_ready_o | output | 1 | One-cycle pulse on a valid frame |
| error_o | output | 1 | Last transaction failed; held until next start |
| humidity_o | output | 8 | Integer humidity of last valid frame |
| temperature_o | output | 8 | Integer temperature of last valid frame |

## Verification
The assertions assume that the line level reaching line_i stays low whenever line_oe_o is high, and that the sensor pulls low only after release. They also assume reset is applied before the first start. The bench models the wired-AND line directly. It scales the clock parameter down so that one count is two microseconds. Its sensor model keeps every pulse width at least five cycles away from each threshold, so that the synchronizer delay cannot push a nominal pulse across a limit. The error cases (early answer, no answer, a bit held low too long, a corrupted checksum) are placed well outside the windows.

// File: rtl/rhs_pkg.sv
package rhs_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WAKE,
    S_WAIT,
    S_ACK_LO,
    S_ACK_HI,
    S_BIT_LO,
    S_BIT_HI,
    S_CHECK,
    S_FAIL
  } rd_state_e;

  function automatic int us_cycles(input longint freq, input longint us);
    return int'((freq * us) / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/rhs_line_sync.sv
module rhs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // idle line reads high through the pull-up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

endmodule

// File: rtl/rhs_frame_shift.sv
module rhs_frame_shift #(
  parameter int NBITS = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [NBITS-1:0] frame_o,
  output logic             full_o,
  output logic             sum_ok_o
);

  localparam int NBYTES = NBITS / 8;
  localparam int CW     = $clog2(NBITS + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(NBITS);

  logic [NBITS-1:0] frame_q;
  logic [CW-1:0]    cnt_q;
  logic [7:0]       sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      cnt_q   <= '0;
    end else if (clear_i) begin
      frame_q <= '0;
      cnt_q   <= '0;
    end else if (shift_i && cnt_q != CNT_FULL) begin
      frame_q <= {frame_q[NBITS-2:0], bit_i};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // checksum over every byte above the last one
  always_comb begin
    sum = '0;
    for (int b = 1; b < NBYTES; b++) sum = sum + frame_q[b*8 +: 8];
  end

  assign frame_o  = frame_q;
  assign full_o   = (cnt_q == CNT_FULL);
  assign sum_ok_o = (sum == frame_q[7:0]);

  p_count_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);

  p_count_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);

endmodule

// File: rtl/rh_sensor_reader.sv
module rh_sensor_reader
  import rhs_pkg::*;
#(
  parameter longint CLK_FREQ = 27_000_000,
  parameter longint START_US = 18_000,
  parameter int     NBITS    = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       line_i,
  output logic       line_oe_o,
  output logic       busy_o,
  output logic       data_ready_o,
  output logic       error_o,
  output logic [7:0] humidity_o,
  output logic [7:0] temperature_o
);

  localparam int T_WAKE = us_cycles(CLK_FREQ, START_US);
  localparam int T_MIN  = us_cycles(CLK_FREQ, 20);
  localparam int T_MAX  = us_cycles(CLK_FREQ, 41);
  localparam int T_ONE  = us_cycles(CLK_FREQ, 60);
  localparam int T_TO   = us_cycles(CLK_FREQ, 100);
  localparam int T_TOP  = (T_WAKE > T_TO) ? T_WAKE : T_TO;
  localparam int CW     = $clog2(T_TOP + 2);

  localparam logic [CW-1:0] LIM_WAKE = CW'(T_WAKE - 1);
  localparam logic [CW-1:0] LIM_MIN  = CW'(T_MIN);
  localparam logic [CW-1:0] LIM_MAX  = CW'(T_MAX);
  localparam logic [CW-1:0] LIM_ONE  = CW'(T_ONE);
  localparam logic [CW-1:0] LIM_TO   = CW'(T_TO);

  rd_state_e        state_q, state_d;
  logic [CW-1:0]    cnt_q;
  logic             lvl, rise, fall;
  logic             accept, shift_en, full, sum_ok;
  logic [NBITS-1:0] frame;
  logic             ready_q;
  logic [7:0]       hum_q, tmp_q;

  rhs_line_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .level_o(lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  rhs_frame_shift #(.NBITS(NBITS)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .shift_i (shift_en),
    .bit_i   (cnt_q > LIM_ONE),
    .frame_o (frame),
    .full_o  (full),
    .sum_ok_o(sum_ok)
  );

  assign accept   = start_i && (state_q == S_IDLE || state_q == S_FAIL);
  assign shift_en = (state_q == S_BIT_LO) && rise;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE, S_FAIL: if (start_i) state_d = S_WAKE;
      S_WAKE:   if (cnt_q == LIM_WAKE) state_d = S_WAIT;
      S_WAIT: begin
        if (fall) state_d = (cnt_q > LIM_MIN && cnt_q < LIM_MAX) ? S_ACK_LO : S_FAIL;
        else if (cnt_q >= LIM_MAX) state_d = S_FAIL;
      end
      S_ACK_LO: if (rise) state_d = S_ACK_HI; else if (cnt_q > LIM_TO) state_d = S_FAIL;
      S_ACK_HI: if (fall) state_d = S_BIT_LO; else if (cnt_q > LIM_TO) state_d = S_FAIL;
      S_BIT_LO: if (rise) state_d = S_BIT_HI; else if (cnt_q > LIM_TO) state_d = S_FAIL;
      S_BIT_HI: begin
        if (full) state_d = S_CHECK;
        else if (fall) state_d = S_BIT_LO;
        else if (cnt_q > LIM_TO) state_d = S_FAIL;
      end
      S_CHECK:  state_d = sum_ok ? S_IDLE : S_FAIL;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      ready_q <= 1'b0;
      hum_q   <= '0;
      tmp_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q || state_d == S_IDLE || state_d == S_FAIL) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
      ready_q <= (state_q == S_CHECK) && sum_ok;
      if (state_q == S_CHECK && sum_ok) begin
        hum_q <= frame[NBITS-1 -: 8];
        tmp_q <= frame[NBITS-17 -: 8];
      end
    end
  end

  assign line_oe_o     = (state_q == S_WAKE);
  assign busy_o        = (state_q != S_IDLE) && (state_q != S_FAIL);
  assign error_o       = (state_q == S_FAIL);
  assign data_ready_o  = ready_q;
  assign humidity_o    = hum_q;
  assign temperature_o = tmp_q;

  p_oe_in_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_oe_o |-> busy_o);

  p_ready_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |=> !data_ready_o);

  p_ready_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |-> !busy_o && !error_o);

  p_error_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o && !start_i |=> error_o);

  p_error_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o && start_i |=> !error_o && busy_o);

  p_no_rewake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !line_oe_o |=> !line_oe_o);

  p_hold_on_fail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_ready_o |-> $stable(humidity_o) && $stable(temperature_o));

endmodule

// File: tb/rh_sensor_reader_test.sv
module rh_sensor_reader_test;

  localparam int CLK_PERIOD = 10;
  localparam int WAKE_CYC   = 9000;   // 18000 us at 500 kHz
  localparam int WATCHDOG   = 190_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       sensor_low = 1'b0;
  logic       line_w;
  logic       oe, busy, ready, err;
  logic [7:0] hum, tmp;

  int n_chk = 0, n_bad = 0;
  int oe_run = 0, oe_rises = 0, rdy_cnt = 0;
  logic oe_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line_w = !(oe || sensor_low);

  rh_sensor_reader #(.CLK_FREQ(500_000), .START_US(18_000)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .line_i(line_w),
    .line_oe_o(oe), .busy_o(busy), .data_ready_o(ready), .error_o(err),
    .humidity_o(hum), .temperature_o(tmp)
  );

  always @(negedge clk) begin
    if (oe && !oe_prev) begin oe_rises++; oe_run = 0; end
    if (oe) oe_run++;
    oe_prev = oe;
    if (ready) rdy_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] mk(input logic [7:0] h, hd, t, td);
    logic [7:0] s = h + hd + t + td;
    return {h, hd, t, td, s};
  endfunction

  // one transaction: wake, sensor answer after dly cycles (dly<0: silent), bit stuck low at index stuck
  task automatic txn(input logic [39:0] fr, input int dly, input int stuck);
    int rises0 = oe_rises;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !err, "R8 busy set, error cleared after start", {busy, err}, 2'b10);
    while (oe) @(negedge clk);
    chk(oe_run == WAKE_CYC, "R1 wake pulse length", oe_run, WAKE_CYC);
    chk(oe_rises == rises0 + 1, "R9 single wake pulse", oe_rises, rises0 + 1);
    if (dly >= 0) begin
      repeat (dly) @(negedge clk);
      sensor_low = 1'b1; repeat (40) @(negedge clk);
      sensor_low = 1'b0; repeat (40) @(negedge clk);
      for (int i = 39; i >= 0; i--) begin
        sensor_low = 1'b1;
        if (i == stuck) begin
          repeat (80) @(negedge clk);
          sensor_low = 1'b0;
          break;
        end
        repeat (fr[i] ? 35 : 25) @(negedge clk);
        sensor_low = 1'b0;
        repeat (25) @(negedge clk);
      end
    end else begin
      repeat (60) @(negedge clk);
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!busy && !err && !ready && !oe, "R10 reset flags", {busy, err, ready, oe}, 0);
    chk(hum == 0 && tmp == 0, "R10 reset data", {hum, tmp}, 0);
  endtask

  task automatic t_good(input logic [7:0] h, hd, t, td);
    int r0 = rdy_cnt;
    txn(mk(h, hd, t, td), 15, -1);
    chk(rdy_cnt == r0 + 1, "R7 one ready pulse", rdy_cnt - r0, 1);
    chk(hum == h, "R4 humidity byte", hum, h);
    chk(tmp == t, "R4 temperature byte", tmp, t);
    chk(!busy && !err, "R7 idle after good frame", {busy, err}, 0);
  endtask

  task automatic t_bad_sum;
    logic [7:0] h0 = hum, t0 = tmp;
    int r0 = rdy_cnt;
    logic [39:0] fr = mk(8'h2D, 8'h00, 8'h17, 8'h00) ^ 40'h1;
    txn(fr, 15, -1);
    chk(err, "R5 error on bad checksum", err, 1);
    chk(rdy_cnt == r0, "R5 no ready on bad checksum", rdy_cnt - r0, 0);
    chk(hum == h0 && tmp == t0, "R5 outputs held", {hum, tmp}, {h0, t0});
  endtask

  task automatic t_early;
    int r0 = rdy_cnt;
    txn(mk(8'h11, 8'h00, 8'h22, 8'h00), 3, -1);
    chk(err && rdy_cnt == r0, "R3 early answer rejected", {err, rdy_cnt - r0}, 1);
  endtask

  task automatic t_silent;
    txn(40'h0, -1, -1);
    chk(err && !busy, "R3 no answer by window end", {err, busy}, 2'b10);
  endtask

  task automatic t_stuck;
    int r0 = rdy_cnt;
    txn(mk(8'h33, 8'h00, 8'h44, 8'h00), 15, 30);
    chk(err && !busy, "R6 stuck low phase timeout", {err, busy}, 2'b10);
    chk(rdy_cnt == r0, "R6 no ready after timeout", rdy_cnt - r0, 0);
  endtask

  task automatic t_busy_start;
    int r0 = rdy_cnt;
    fork
      txn(mk(8'h2D, 8'h00, 8'h17, 8'h00), 15, -1);
      begin
        repeat (9600) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
    join
    chk(rdy_cnt == r0 + 1 && !err, "R9 start while busy ignored", rdy_cnt - r0, 1);
    chk(hum == 8'h2D && tmp == 8'h17, "R9 frame intact", {hum, tmp}, 16'h2D17);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_good(8'h2D, 8'h00, 8'h17, 8'h00);
        t_good(8'h5A, 8'h07, 8'hE3, 8'h09);  // checksum wraps past 8 bits
        t_bad_sum();
        t_early();
        t_silent();
        t_stuck();
        t_busy_start();
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <%0d cycles", WATCHDOG, WATCHDOG);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule